// File: doc/BRIEF.md
# Slew Rate Calibration Sequencer

This block runs one calibration pass for the slew-rate control of a high-speed transmitter. A one-cycle start pulse begins the pass. The block first turns on a ring oscillator and waits for it to settle. It then enables a free-running clock, loads a measurement window of 1024 cycles and arms a frequency meter. It polls the meter's valid flag at a fixed interval, up to a timeout, and then captures the meter's count. After that it shuts down the meter and the free-running clock, works out a 3-bit slew code, writes the code and turns the oscillator off. A one-cycle done pulse ends the pass.

The code is the reference frequency in MHz, times the coefficient, times the window length, divided by the measured count. That result is then divided by 1000 and rounded to the nearest integer. Both divisions run one after the other on a single multi-cycle restoring divider. A zero count selects a fixed fallback code. Any result above 7 is clamped to 7. All time intervals are derived from the system clock through a microsecond prescaler.

Top module: `slew_cal_seq`

## Requirements
- R1: After reset, all four meter controls (oscillator, free-run clock, meter enable, window) and the slew code are 0, and busy, done and timeout are low.
- R2: A pass runs in this strict order: oscillator on; at least SETTLE_US µs of settling; free-run clock on; window set to 1024; meter on; meter off; free-run clock off; code written; oscillator off. The code changes only while the oscillator is on and the free-run clock is off.
- R3: The valid flag is sampled in the first poll cycle and then once every POLL_US µs. The count is captured at the first sample where valid is high. The meter turns off no later than POLL_US µs (plus a few cycles) after valid rises.
- R4: If valid has not been seen by the sample at TIMEOUT_US µs, the pass is not aborted. The count input is captured at that point and used as normal, and timeout_o reads 1 from the done pulse until the next done.
- R5: With a nonzero count N, the code is round((R·C·1024 / N) / 1000). The inner division is an integer floor division. Rounding adds 500 before the floor division by 1000, so a quotient of 1500 gives 2 and 1497 gives 1.
- R6: The reference and coefficient inputs are sampled at start. A value of 0 on the reference selects 26 MHz, and a value of 0 on the coefficient selects 17.
- R7: A captured count of 0 writes the fallback code 4, and no division is performed.
- R8: A computed code above 7 is written as 7.
- R9: done_o is a single-cycle pulse. In the cycle it is high, the oscillator, free-run clock and meter are off and busy_o is low.
- R10: A start pulse received while a pass is in progress is ignored. No second pass runs, and inputs changed mid-pass do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_MHZ MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a pass |
| ref_mhz_i | input | REF_W | Reference frequency in MHz; 0 selects the default |
| coef_i | input | COEF_W | Calibration coefficient; 0 selects the default |
| fm_valid_i | input | 1 | Frequency meter result valid |
| fm_count_i | input | CNT_W | Frequency meter count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running clock enable |
| fm_en_o | output | 1 | Frequency meter enable |
| fm_window_o | output | CNT_W | Measurement window length in cycles |
| slew_code_o | output | CODE_W | Slew-rate control code |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| timeout_o | output | 1 | Last pass ended on poll timeout |

## Verification
The assertions assume two things about the inputs: start_i arrives only as a pulse, and the meter raises valid only after its enable has risen. The bench meets both. Its driver releases start one cycle after raising it, and it raises valid only a set delay after it sees the meter enable rise. Before valid rises, the bench holds a deliberately wrong count on the count input, so a capture taken too early would give a different code. The divider checks also assume that the divisor is never zero when the divider starts; the sequencer's zero-count bypass is what guarantees this.

// File: rtl/slew_cal_pkg.sv
// Shared types for the slew-rate calibration sequencer.
// Assumes: a single state encoding used by the top-level FSM only.
package slew_cal_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LOADW,
        ST_ARM,
        ST_POLL,
        ST_STOP,
        ST_CLKOFF,
        ST_DIV1,
        ST_DIV2,
        ST_WRITE,
        ST_OFF
    } cal_state_e;
endpackage

// File: rtl/slew_cal_tick.sv
// Microsecond prescaler: pulses tick_o once every CYC_PER_US cycles.
// Assumes: clr_i restarts the count so the first tick comes a full
// microsecond after the clear.
module slew_cal_tick #(
    parameter int CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Count cycles within the current microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || tick_o) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/slew_cal_div.sv
// Restoring unsigned divider, one quotient bit per cycle (DW cycles).
// Assumes: start_i is raised only while idle and with a nonzero divisor;
// done_o pulses for one cycle with quot_o valid in that cycle.
module slew_cal_div #(
    parameter int DW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic          done_o,
    output logic [DW-1:0] quot_o
);
    localparam int CW = $clog2(DW + 1);
    localparam int W2 = 2 * DW;

    logic          busy_q;
    logic [CW-1:0] step_q;
    logic [DW-1:0] a_q, den_q, quo_q, rem_q;
    logic [DW:0]   rem_sh;
    logic          fits;
    logic [DW-1:0] rem_nx, quo_nx;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        rem_sh = {rem_q, quo_q[DW-1]};
        fits   = (rem_sh >= {1'b0, den_q});
        rem_nx = fits ? DW'(rem_sh - {1'b0, den_q}) : rem_sh[DW-1:0];
        quo_nx = {quo_q[DW-2:0], fits};
    end

    // Load operands on start, iterate while busy, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_o <= 1'b0;
            step_q <= '0;
            a_q    <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                step_q <= CW'(DW);
                a_q    <= dividend_i;
                den_q  <= divisor_i;
                quo_q  <= dividend_i;
                rem_q  <= '0;
            end else if (busy_q) begin
                quo_q  <= quo_nx;
                rem_q  <= rem_nx;
                step_q <= step_q - 1'b1;
                if (step_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quo_q;

    // R5: the quotient and remainder must reconstruct the dividend exactly.
    assert_div_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((W2'(quo_q) * W2'(den_q) + W2'(rem_q)) == W2'(a_q)) && (rem_q < den_q));

    // R7: the sequencer never starts a division with a zero divisor or while busy.
    assert_div_start_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q && (divisor_i != '0));
endmodule

// File: rtl/slew_cal_seq.sv
// Slew-rate calibration sequencer top level.
// Runs oscillator settle, frequency measurement with timed polling,
// shutdown, code computation on a shared divider, code write.
// Assumes: start_i is a pulse; the meter holds fm_count_i while valid.
module slew_cal_seq
    import slew_cal_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int REF_W       = 8,
    parameter int COEF_W      = 8,
    parameter int CNT_W       = 24,
    parameter int CODE_W      = 3,
    parameter int WINDOW      = 1024,
    parameter int SETTLE_US   = 1,
    parameter int POLL_US     = 10,
    parameter int TIMEOUT_US  = 200,
    parameter int DEF_REF_MHZ = 26,
    parameter int DEF_COEF    = 17,
    parameter int SCALE       = 1000,
    parameter int DEF_CODE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REF_W-1:0]  ref_mhz_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic              fm_valid_i,
    input  logic [CNT_W-1:0]  fm_count_i,
    output logic              osc_en_o,
    output logic              frck_en_o,
    output logic              fm_en_o,
    output logic [CNT_W-1:0]  fm_window_o,
    output logic [CODE_W-1:0] slew_code_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    localparam int WIN_BITS   = $clog2(WINDOW + 1);
    localparam int NUM_W      = REF_W + COEF_W + WIN_BITS;
    localparam int DW         = ((NUM_W > CNT_W) ? NUM_W : CNT_W) + 1;
    localparam int US_MAX     = (TIMEOUT_US > SETTLE_US) ? TIMEOUT_US : SETTLE_US;
    localparam int US_W       = $clog2(US_MAX + 1);
    localparam int PC_W       = $clog2(POLL_US + 1);
    localparam int CODE_MAX   = (1 << CODE_W) - 1;
    localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
    localparam int SC_W       = $clog2(SETTLE_CYC + 2);

    cal_state_e        state_q, state_d;
    logic              fresh_q, tmo_q, tick, sample;
    logic [US_W-1:0]   us_q;
    logic [PC_W-1:0]   pcnt_q;
    logic [US_W:0]     elapsed;
    logic [REF_W-1:0]  ref_q;
    logic [COEF_W-1:0] coef_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] calc_q;
    logic              div_start, div_done;
    logic [DW-1:0]     div_a, div_b, div_q;

    slew_cal_tick #(.CYC_PER_US(CLK_MHZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(state_d != state_q), .tick_o(tick)
    );

    slew_cal_div #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start_i(div_start),
        .dividend_i(div_a), .divisor_i(div_b), .done_o(div_done), .quot_o(div_q)
    );

    // Poll sample points: first poll cycle, then every POLL_US microseconds.
    assign sample  = fresh_q || (tick && pcnt_q == PC_W'(POLL_US - 1));
    assign elapsed = {1'b0, us_q} + (US_W + 1)'(tick);

    // Next-state logic and divider operand selection.
    always_comb begin
        state_d   = state_q;
        div_start = 1'b0;
        div_a     = DW'(ref_q) * DW'(coef_q) * DW'(WINDOW);
        div_b     = DW'(cnt_q);
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETTLE;
            ST_SETTLE: if (tick && us_q == US_W'(SETTLE_US - 1)) state_d = ST_LOADW;
            ST_LOADW:  state_d = ST_ARM;
            ST_ARM:    state_d = ST_POLL;
            ST_POLL:   if (sample && (fm_valid_i || elapsed >= (US_W + 1)'(TIMEOUT_US)))
                           state_d = ST_STOP;
            ST_STOP:   state_d = ST_CLKOFF;
            ST_CLKOFF: begin
                if (cnt_q == '0) state_d = ST_WRITE;
                else begin
                    div_start = 1'b1;
                    state_d   = ST_DIV1;
                end
            end
            ST_DIV1: begin
                div_a = div_q + DW'(SCALE / 2);
                div_b = DW'(SCALE);
                if (div_done) begin
                    div_start = 1'b1;
                    state_d   = ST_DIV2;
                end
            end
            ST_DIV2:   if (div_done) state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_OFF;
            ST_OFF:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Microsecond and poll-interval counters, restarted on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            us_q    <= '0;
            pcnt_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            fresh_q <= (state_d != state_q);
            if (state_d != state_q) begin
                us_q   <= '0;
                pcnt_q <= '0;
            end else if (tick) begin
                if (us_q != US_W'(US_MAX)) us_q <= us_q + 1'b1;
                pcnt_q <= (pcnt_q == PC_W'(POLL_US - 1)) ? '0 : pcnt_q + 1'b1;
            end
        end
    end

    // State register and the control actions taken on each transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            osc_en_o    <= 1'b0;
            frck_en_o   <= 1'b0;
            fm_en_o     <= 1'b0;
            fm_window_o <= '0;
            slew_code_o <= '0;
            busy_o      <= 1'b0;
            done_o      <= 1'b0;
            timeout_o   <= 1'b0;
            tmo_q       <= 1'b0;
            ref_q       <= '0;
            coef_q      <= '0;
            cnt_q       <= '0;
            calc_q      <= '0;
        end else begin
            state_q <= state_d;
            done_o  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    osc_en_o <= 1'b1;
                    busy_o   <= 1'b1;
                    tmo_q    <= 1'b0;
                    ref_q    <= (ref_mhz_i == '0) ? REF_W'(DEF_REF_MHZ) : ref_mhz_i;
                    coef_q   <= (coef_i == '0) ? COEF_W'(DEF_COEF) : coef_i;
                end
                ST_SETTLE: if (state_d == ST_LOADW) frck_en_o <= 1'b1;
                ST_LOADW:  fm_window_o <= CNT_W'(WINDOW);
                ST_ARM:    fm_en_o <= 1'b1;
                ST_POLL: if (state_d == ST_STOP) begin
                    cnt_q <= fm_count_i;
                    tmo_q <= !fm_valid_i;
                end
                ST_STOP:   fm_en_o <= 1'b0;
                ST_CLKOFF: begin
                    frck_en_o <= 1'b0;
                    if (cnt_q == '0) calc_q <= CODE_W'(DEF_CODE);
                end
                ST_DIV1:   ;
                ST_DIV2: if (div_done)
                    calc_q <= (div_q > DW'(CODE_MAX)) ? CODE_W'(CODE_MAX) : div_q[CODE_W-1:0];
                ST_WRITE:  slew_code_o <= calc_q;
                ST_OFF: begin
                    osc_en_o  <= 1'b0;
                    busy_o    <= 1'b0;
                    done_o    <= 1'b1;
                    timeout_o <= tmo_q;
                end
                default: ;
            endcase
        end
    end

    // Checker counter: cycles the oscillator has run before the free-run clock.
    logic [SC_W-1:0] settle_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en_o) settle_cnt <= '0;
        else if (!frck_en_o && settle_cnt != SC_W'(SETTLE_CYC + 1)) settle_cnt <= settle_cnt + 1'b1;
    end

    assert_clk_after_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frck_en_o) |-> osc_en_o && (settle_cnt >= SC_W'(SETTLE_CYC)));

    assert_meter_needs_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fm_en_o |-> frck_en_o && (fm_window_o == CNT_W'(WINDOW)));

    assert_code_write_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slew_code_o) |-> osc_en_o && !frck_en_o && !fm_en_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !osc_en_o && !frck_en_o && !fm_en_o && !busy_o);

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/tb_slew_cal_seq.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// them on each done pulse and checks the control ordering as it happens.
module tb_slew_cal_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  ref_mhz_i = '0;
    logic [7:0]  coef_i = '0;
    logic        fm_valid_i = 1'b0;
    logic [23:0] fm_count_i = '0;
    logic        osc_en_o, frck_en_o, fm_en_o, busy_o, done_o, timeout_o;
    logic [23:0] fm_window_o;
    logic [2:0]  slew_code_o;

    slew_cal_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_mhz_i(ref_mhz_i),
        .coef_i(coef_i), .fm_valid_i(fm_valid_i), .fm_count_i(fm_count_i),
        .osc_en_o(osc_en_o), .frck_en_o(frck_en_o), .fm_en_o(fm_en_o),
        .fm_window_o(fm_window_o), .slew_code_o(slew_code_o), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, n_done = 0, n_push = 0;
    longint cyc = 0;
    longint osc_rise = 0, fm_rise = 0, valid_at = 0;
    bit run_tmo = 0;
    bit finished = 0;
    logic [3:0] exp_q[$];
    logic p_osc = 0, p_frck = 0, p_fm = 0, p_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input int r, input int c, input int n);
        longint rr, cc, q, k;
        rr = (r == 0) ? 26 : r;
        cc = (c == 0) ? 17 : c;
        if (n == 0) return 3'd4;
        q = (rr * cc * 1024) / n;
        k = (q + 500) / 1000;
        if (k > 7) k = 7;
        return 3'(k);
    endfunction

    // Monitor: ordering checks on control edges and scoreboard pops on done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (osc_en_o && !p_osc) osc_rise = cyc;
            if (frck_en_o && !p_frck)
                chk(osc_en_o && (cyc - osc_rise) >= 125, "R2", "settle cycles before free-run clock",
                    cyc - osc_rise, 125);
            if (fm_en_o && !p_fm) begin
                fm_rise = cyc;
                chk(frck_en_o && fm_window_o == 24'd1024, "R2", "window at meter enable",
                    fm_window_o, 1024);
            end
            if (!fm_en_o && p_fm) begin
                chk(frck_en_o && osc_en_o, "R2", "clock and osc on at meter off", frck_en_o, 1);
                if (run_tmo)
                    chk((cyc - fm_rise) >= 25000, "R4", "cycles to timeout", cyc - fm_rise, 25000);
                else
                    chk((cyc - valid_at) >= 1 && (cyc - valid_at) <= 1260, "R3",
                        "cycles from valid to meter off", cyc - valid_at, 1250);
            end
            if (!frck_en_o && p_frck)
                chk(!fm_en_o, "R2", "meter off before clock off", fm_en_o, 0);
            if (p_done)
                chk(!done_o, "R9", "done pulse width", done_o, 0);
            if (done_o) begin
                n_done++;
                chk(!osc_en_o && !frck_en_o && !fm_en_o && !busy_o, "R9", "quiet at done",
                    {osc_en_o, frck_en_o, fm_en_o, busy_o}, 0);
                if (exp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
                else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    chk(slew_code_o == e[2:0], "R5", "slew code", slew_code_o, e[2:0]);
                    chk(timeout_o == e[3], "R4", "timeout flag", timeout_o, e[3]);
                end
            end
            p_osc = osc_en_o; p_frck = frck_en_o; p_fm = fm_en_o; p_done = done_o;
        end
    end

    // Driver: one pass with a meter model; optional late valid, no valid, or mid-pass start.
    task automatic run_cal(input int r, input int c, input int n, input int dly,
                           input bit never, input bit garbage, input bit midstart);
        exp_q.push_back({never, model(r, c, n)});
        n_push++;
        run_tmo = never;
        ref_mhz_i = 8'(r);
        coef_i = 8'(c);
        fm_valid_i = 1'b0;
        fm_count_i = garbage ? 24'd1 : 24'(n);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!fm_en_o) @(negedge clk);
        if (midstart) begin
            ref_mhz_i = 8'd200;
            coef_i = 8'd200;
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        if (!never) begin
            repeat (dly) @(negedge clk);
            fm_count_i = 24'(n);
            fm_valid_i = 1'b1;
            valid_at = cyc;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk) fm_valid_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!osc_en_o && !frck_en_o && !fm_en_o, "R1", "enables after reset",
            {osc_en_o, frck_en_o, fm_en_o}, 0);
        chk(fm_window_o == 0 && slew_code_o == 0, "R1", "window and code after reset",
            slew_code_o, 0);
        chk(!busy_o && !done_o && !timeout_o, "R1", "status after reset",
            {busy_o, done_o, timeout_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_cal(0, 0, 113, 300, 0, 0, 0);    // R6 defaults: code 4
        run_cal(26, 17, 150, 40, 0, 0, 0);   // R5: code 3
        run_cal(250, 3, 512, 20, 0, 0, 0);   // R5 round-half-up: 2
        run_cal(250, 3, 513, 20, 0, 0, 0);   // R5 just below half: 1
        run_cal(0, 0, 1, 10, 0, 0, 0);       // R8 clamp to 7
        run_cal(0, 0, 0, 10, 0, 0, 0);       // R7 fallback 4
        run_cal(0, 10, 90, 3000, 0, 1, 0);   // R3 late valid, early count wrong; R6 ref default
        run_cal(0, 0, 90, 0, 1, 0, 0);       // R4 timeout, count still used: 5
        run_cal(30, 20, 1024, 50, 0, 0, 1);  // R10 mid-pass start ignored: 1
        repeat (200) @(negedge clk);
        chk(n_done == n_push && exp_q.size() == 0, "R10", "passes completed", n_done, n_push);
        chk(!busy_o && !osc_en_o, "R10", "idle after ignored start", busy_o, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", n_done, n_push);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule